// File: doc/BRIEF.md
# Key-Locked Configuration Port Decoder

This block decodes a two-address configuration port of the kind found on legacy I/O controllers. The host reaches it through a byte-wide strobe interface with one address bit. Address 0 is the index port and address 1 is the data port. The data port reaches whatever register the index port last named. At reset the port is locked. It opens only after a fixed unlock byte has been written to the index port a set number of times in a row. A separate lock byte written to the index port closes it again.

Once the port is open, a few global registers live inside the block:
- a logical-device select register;
- a chip identifier, a revision byte and a manufacturer identifier, all read-only and all fixed by parameters.

Register numbers from the forwarding base upward belong to the logical device chosen by the select register. Accesses to them go out on a simple downstream register bus: an address, write data, a write pulse, a read pulse, and read data that returns in the same cycle. Only the general-purpose I/O device is present. A select value that names any other device reads back all ones, and writes to it go nowhere. Host read data is registered and appears one cycle after the read strobe.

Top module: `cfgport_dec`

## Requirements
- R1: After reset the port is locked, host_rvalid is low, and reads of either port return 0xFF.
- R2: The port opens only after the index port receives 0x87 twice in a row. Any other index-port byte between the two restarts the count. Reads and data-port accesses do not affect the count.
- R3: Writing 0xAA to the index port while open locks the port. Later reads of both ports then return 0xFF.
- R4: While the port is locked, data-port writes have no effect: no downstream write occurs and no register changes. Index-port writes other than the key bytes are not latched.
- R5: While open, a read of the index port returns the last index written.
- R6: Register 0x07 is the logical-device select register. It is readable and writable and resets to 0x00.
- R7: Registers 0x20 and 0x21 hold the chip ID, high byte at 0x20. Register 0x22 holds the revision. Registers 0x23 and 0x24 hold 0x1934, high byte at 0x23. Writes to these five registers are ignored.
- R8: With select equal to 0x06 and index at 0x30 or above, a data-port write gives a one-cycle ld_wr with ld_addr equal to the index and ld_wdata equal to the host byte. A data-port read gives a one-cycle ld_rd and returns ld_rdata.
- R9: With any other select value and index at 0x30 or above, data-port reads return 0xFF and no ld_wr or ld_rd occurs.
- R10: host_rdata is updated, and host_rvalid is high for exactly one cycle, on the clock edge that samples host_rd. host_rvalid is low after any cycle with no read.
- R11: When host_rd and host_wr are both asserted in one cycle, the read returns the state from before the write. If that register is forwarded, both ld_rd and ld_wr pulse.
- R12: Unimplemented global registers below 0x30 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 1 | 0 selects the index port, 1 the data port |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| host_rvalid | output | 1 | host_rdata carries a fresh result |
| ld_addr | output | 8 | Downstream register number (the current index) |
| ld_wdata | output | 8 | Downstream write byte |
| ld_wr | output | 1 | Downstream write pulse |
| ld_rd | output | 1 | Downstream read pulse |
| ld_rdata | input | 8 | Downstream read byte, valid in the ld_rd cycle |

## Verification
The host strobes share one address bit, so a read and a write to the same port can arrive in the same cycle. The result depends on which one the decoder lets win. The bench drives both strobes together on the select register, checks that the read returns the old select value, and then reads again to see the new one. It repeats this on a forwarded register. There it expects both downstream pulses in that one cycle, and read data taken from the device before the write.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   // Source of the byte captured into the host read register.
   typedef enum logic [2:0] {
      SRC_ONES,
      SRC_ZERO,
      SRC_INDEX,
      SRC_SELECT,
      SRC_IDENT,
      SRC_DEVICE
   } rd_src_e;

   localparam int IDENT_BYTES = 5;

endpackage

// File: rtl/cfgp_lock.sv
module cfgp_lock #(
   parameter int             DW         = 8,
   parameter logic [DW-1:0]  UNLOCK_KEY = 8'h87,
   parameter logic [DW-1:0]  LOCK_KEY   = 8'hAA,
   parameter int             KEY_WRITES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idx_wr,
   input  logic [DW-1:0] wdata,
   output logic          unlocked
);

   generate
      if (KEY_WRITES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               unlocked <= 1'b0;
            end else if (idx_wr) begin
               if (!unlocked && wdata == UNLOCK_KEY)
                  unlocked <= 1'b1;
               else if (unlocked && wdata == LOCK_KEY)
                  unlocked <= 1'b0;
            end
         end
      end else begin : g_count
         localparam int CW = $clog2(KEY_WRITES);
         localparam logic [CW-1:0] LAST = CW'(KEY_WRITES - 1);
         logic [CW-1:0] seen;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               unlocked <= 1'b0;
               seen     <= '0;
            end else if (idx_wr) begin
               if (unlocked) begin
                  if (wdata == LOCK_KEY)
                     unlocked <= 1'b0;
                  seen <= '0;
               end else if (wdata == UNLOCK_KEY) begin
                  if (seen == LAST) begin
                     unlocked <= 1'b1;
                     seen     <= '0;
                  end else begin
                     seen <= seen + 1'b1;
                  end
               end else begin
                  seen <= '0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cfgp_glob_regs.sv
module cfgp_glob_regs
   import cfgp_pkg::*;
#(
   parameter int              DW       = 8,
   parameter logic [DW-1:0]   LOCK_KEY = 8'hAA,
   parameter logic [DW-1:0]   SEL_IDX  = 8'h07,
   parameter logic [DW-1:0]   ID_BASE  = 8'h20,
   parameter logic [2*DW-1:0] CHIP_ID  = 16'h5A21,
   parameter logic [DW-1:0]   CHIP_REV = 8'h03,
   parameter logic [2*DW-1:0] MFR_ID   = 16'h1934
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          unlocked,
   input  logic          idx_wr,
   input  logic          data_wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] index,
   output logic [DW-1:0] sel,
   output logic          id_hit,
   output logic [DW-1:0] id_data
);

   logic [IDENT_BYTES-1:0][DW-1:0] id_tab;
   logic [DW-1:0]                  offset;

   assign id_tab[0] = CHIP_ID[2*DW-1:DW];
   assign id_tab[1] = CHIP_ID[DW-1:0];
   assign id_tab[2] = CHIP_REV;
   assign id_tab[3] = MFR_ID[2*DW-1:DW];
   assign id_tab[4] = MFR_ID[DW-1:0];

   assign offset = index - ID_BASE;
   assign id_hit = (index >= ID_BASE) && (offset < DW'(IDENT_BYTES));

   always_comb begin
      id_data = '0;
      for (int k = 0; k < IDENT_BYTES; k++)
         if (offset == DW'(k))
            id_data = id_tab[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index <= '0;
      end else if (idx_wr && unlocked && wdata != LOCK_KEY) begin
         index <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel <= '0;
      end else if (data_wr && unlocked && index == SEL_IDX) begin
         sel <= wdata;
      end
   end

endmodule

// File: rtl/cfgp_route.sv
module cfgp_route
   import cfgp_pkg::*;
#(
   parameter int            DW       = 8,
   parameter logic [DW-1:0] SEL_IDX  = 8'h07,
   parameter logic [DW-1:0] FWD_BASE = 8'h30,
   parameter logic [DW-1:0] GPIO_LDN = 8'h06
) (
   input  logic          unlocked,
   input  logic          host_addr,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [DW-1:0] host_wdata,
   input  logic [DW-1:0] index,
   input  logic [DW-1:0] sel,
   input  logic          id_hit,
   input  logic [DW-1:0] id_data,
   input  logic [DW-1:0] ld_rdata,
   output logic [DW-1:0] ld_addr,
   output logic [DW-1:0] ld_wdata,
   output logic          ld_wr,
   output logic          ld_rd,
   output logic [DW-1:0] rd_next
);

   logic    fwd_zone;
   logic    dev_ok;
   logic    fwd;
   rd_src_e src;

   assign fwd_zone = index >= FWD_BASE;
   assign dev_ok   = sel == GPIO_LDN;
   assign fwd      = unlocked && host_addr && fwd_zone && dev_ok;

   assign ld_addr  = index;
   assign ld_wdata = host_wdata;
   assign ld_wr    = fwd && host_wr;
   assign ld_rd    = fwd && host_rd;

   always_comb begin
      if (!unlocked)             src = SRC_ONES;
      else if (!host_addr)       src = SRC_INDEX;
      else if (index == SEL_IDX) src = SRC_SELECT;
      else if (id_hit)           src = SRC_IDENT;
      else if (fwd_zone)         src = dev_ok ? SRC_DEVICE : SRC_ONES;
      else                       src = SRC_ZERO;
   end

   always_comb begin
      unique case (src)
         SRC_ONES:   rd_next = '1;
         SRC_ZERO:   rd_next = '0;
         SRC_INDEX:  rd_next = index;
         SRC_SELECT: rd_next = sel;
         SRC_IDENT:  rd_next = id_data;
         SRC_DEVICE: rd_next = ld_rdata;
         default:    rd_next = '1;
      endcase
   end

endmodule

// File: rtl/cfgport_dec.sv
module cfgport_dec #(
   parameter int            DW         = 8,
   parameter logic [DW-1:0] UNLOCK_KEY = 8'h87,
   parameter logic [DW-1:0] LOCK_KEY   = 8'hAA,
   parameter int            KEY_WRITES = 2,
   parameter logic [DW-1:0] SEL_IDX    = 8'h07,
   parameter logic [DW-1:0] GPIO_LDN   = 8'h06,
   parameter logic [DW-1:0] ID_BASE    = 8'h20,
   parameter logic [DW-1:0] FWD_BASE   = 8'h30,
   parameter logic [15:0]   CHIP_ID    = 16'h5A21,
   parameter logic [7:0]    CHIP_REV   = 8'h03,
   parameter logic [15:0]   MFR_ID     = 16'h1934
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_addr,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          host_rvalid,
   output logic [DW-1:0] ld_addr,
   output logic [DW-1:0] ld_wdata,
   output logic          ld_wr,
   output logic          ld_rd,
   input  logic [DW-1:0] ld_rdata
);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("cfgport_dec: DW must be 8");
      end
      if (KEY_WRITES < 1) begin : g_bad_keys
         $error("cfgport_dec: KEY_WRITES must be at least 1");
      end
      if (UNLOCK_KEY == LOCK_KEY) begin : g_bad_key_pair
         $error("cfgport_dec: unlock and lock bytes must differ");
      end
      if (FWD_BASE <= ID_BASE + DW'(4)) begin : g_bad_fwd
         $error("cfgport_dec: forwarding base overlaps identity registers");
      end
      if (SEL_IDX >= ID_BASE) begin : g_bad_sel
         $error("cfgport_dec: select register must sit below identity registers");
      end
   endgenerate

   logic          unlocked;
   logic          idx_wr;
   logic          data_wr;
   logic [DW-1:0] index;
   logic [DW-1:0] sel;
   logic          id_hit;
   logic [DW-1:0] id_data;
   logic [DW-1:0] rd_next;

   assign idx_wr  = host_wr && !host_addr;
   assign data_wr = host_wr && host_addr;

   cfgp_lock #(
      .DW(DW), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY), .KEY_WRITES(KEY_WRITES)
   ) u_lock (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(host_wdata), .unlocked(unlocked)
   );

   cfgp_glob_regs #(
      .DW(DW), .LOCK_KEY(LOCK_KEY), .SEL_IDX(SEL_IDX), .ID_BASE(ID_BASE),
      .CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .MFR_ID(MFR_ID)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .idx_wr(idx_wr),
      .data_wr(data_wr), .wdata(host_wdata), .index(index), .sel(sel),
      .id_hit(id_hit), .id_data(id_data)
   );

   cfgp_route #(
      .DW(DW), .SEL_IDX(SEL_IDX), .FWD_BASE(FWD_BASE), .GPIO_LDN(GPIO_LDN)
   ) u_route (
      .unlocked(unlocked), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .index(index), .sel(sel),
      .id_hit(id_hit), .id_data(id_data), .ld_rdata(ld_rdata),
      .ld_addr(ld_addr), .ld_wdata(ld_wdata), .ld_wr(ld_wr), .ld_rd(ld_rd),
      .rd_next(rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
      end else begin
         host_rvalid <= host_rd;
         if (host_rd)
            host_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/cfgport_dec_chk.sv
module cfgport_dec_chk #(
   parameter int            DW         = 8,
   parameter logic [DW-1:0] UNLOCK_KEY = 8'h87,
   parameter logic [DW-1:0] LOCK_KEY   = 8'hAA
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_addr,
   input logic          host_wr,
   input logic          host_rd,
   input logic [DW-1:0] host_wdata,
   input logic [DW-1:0] host_rdata,
   input logic          host_rvalid,
   input logic          ld_wr,
   input logic          ld_rd,
   input logic          unlocked
);

   // R10: every read strobe yields exactly one valid cycle
   p_rvalid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> host_rvalid);
   p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> !host_rvalid);

   // R1 and R3: a read taken while locked returns all ones
   p_locked_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !unlocked) |=> host_rdata == '1);

   // R2: the port only opens on the edge that takes an unlock byte at the index port
   p_open_on_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(host_wr && !host_addr && host_wdata == UNLOCK_KEY));

   // R3: the lock byte closes an open port
   p_lock_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && host_wr && !host_addr && host_wdata == LOCK_KEY) |=> !unlocked);

   // R4: nothing reaches the device while locked
   p_no_fwd_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> (!ld_wr && !ld_rd));

   // R8: downstream pulses only accompany a host data-port strobe
   p_ldwr_from_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_wr |-> (host_wr && host_addr));
   p_ldrd_from_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rd |-> (host_rd && host_addr));

endmodule

bind cfgport_dec cfgport_dec_chk #(
   .DW(DW), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
   .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
   .host_rvalid(host_rvalid), .ld_wr(ld_wr), .ld_rd(ld_rd), .unlocked(unlocked)
);

// File: tb/cfgport_dec_tb.sv
module cfgport_dec_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] DEV_XOR = 8'h5C;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_addr = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       host_rvalid;
   logic [7:0] ld_addr;
   logic [7:0] ld_wdata;
   logic       ld_wr;
   logic       ld_rd;
   logic [7:0] ld_rdata;

   int checks = 0;
   int failures = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // Device model: read data is a fixed function of the register number
   assign ld_rdata = ld_addr ^ DEV_XOR;

   cfgport_dec u_dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
      .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_rdata(ld_rdata)
   );

   task automatic check(input bit ok, input string tag, input logic [7:0] act,
                        input logic [7:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard whenever a result is presented
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected rvalid", host_rdata, 8'h00);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(host_rdata == e, t, host_rdata, e);
         end
      end
   end

   // One host access lasting two cycles; checks downstream pulses in the strobe cycle
   task automatic access(input logic a, input bit wr, input logic [7:0] wd,
                         input bit rd, input logic [7:0] exp_rd,
                         input bit exp_ldwr, input bit exp_ldrd, input string tag);
      @(negedge clk);
      host_addr  = a;
      host_wr    = wr;
      host_rd    = rd;
      host_wdata = wd;
      if (rd) begin
         exp_q.push_back(exp_rd);
         tag_q.push_back(tag);
      end
      #1;
      check(ld_wr == exp_ldwr, {tag, " ld_wr"}, {7'd0, ld_wr}, {7'd0, exp_ldwr});
      check(ld_rd == exp_ldrd, {tag, " ld_rd"}, {7'd0, ld_rd}, {7'd0, exp_ldrd});
      if (exp_ldwr) begin
         check(ld_wdata == wd, {tag, " ld_wdata"}, ld_wdata, wd);
      end
      @(posedge clk);
      @(negedge clk);
      host_wr = 1'b0;
      host_rd = 1'b0;
      if (!rd) begin
         #1;
         check(host_rvalid == 1'b0, "R10 rvalid idle", {7'd0, host_rvalid}, 8'h00);
      end
   endtask

   task automatic iw(input logic [7:0] v);
      access(1'b0, 1'b1, v, 1'b0, 8'h00, 1'b0, 1'b0, "index write");
   endtask

   task automatic dw(input logic [7:0] v, input bit fwd, input string tag);
      access(1'b1, 1'b1, v, 1'b0, 8'h00, fwd, 1'b0, tag);
   endtask

   task automatic rdp(input logic a, input logic [7:0] e, input bit fwd, input string tag);
      access(a, 1'b0, 8'h00, 1'b1, e, 1'b0, fwd, tag);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(host_rvalid == 1'b0, "R1 rvalid at reset", {7'd0, host_rvalid}, 8'h00);

      // R1: locked reads return all ones
      rdp(1'b0, 8'hFF, 1'b0, "R1 locked index read");
      rdp(1'b1, 8'hFF, 1'b0, "R1 locked data read");

      // R4: locked data-port write and index write do nothing
      iw(8'h07);
      dw(8'h55, 1'b0, "R4 locked data write");

      // R2: interrupted key does not open
      iw(8'h87);
      iw(8'h12);
      iw(8'h87);
      rdp(1'b1, 8'hFF, 1'b0, "R2 still locked after broken key");
      rdp(1'b0, 8'hFF, 1'b0, "R2 still locked index read");
      iw(8'h87);
      // R5 / R4: index not latched while locked, still reset value
      rdp(1'b0, 8'h00, 1'b0, "R5 index after unlock");
      // R12: index 0 is an unimplemented global register
      dw(8'h33, 1'b0, "R12 write unimplemented");
      rdp(1'b1, 8'h00, 1'b0, "R12 read unimplemented");

      // R6 / R4: select reset value untouched by the locked write
      iw(8'h07);
      rdp(1'b1, 8'h00, 1'b0, "R6 select reset value");
      dw(8'h06, 1'b0, "R6 select write");
      rdp(1'b1, 8'h06, 1'b0, "R6 select readback");

      // R7: identity registers
      iw(8'h20); rdp(1'b1, 8'h5A, 1'b0, "R7 chip id high");
      iw(8'h21); rdp(1'b1, 8'h21, 1'b0, "R7 chip id low");
      iw(8'h22); rdp(1'b1, 8'h03, 1'b0, "R7 revision");
      iw(8'h23); rdp(1'b1, 8'h19, 1'b0, "R7 vendor id high");
      iw(8'h24); rdp(1'b1, 8'h34, 1'b0, "R7 vendor id low");
      iw(8'h20); dw(8'hEE, 1'b0, "R7 write to id");
      rdp(1'b1, 8'h5A, 1'b0, "R7 id unchanged");

      // R8: forwarding to the selected device
      iw(8'h31);
      @(negedge clk);
      #1;
      check(ld_addr == 8'h31, "R8 ld_addr", ld_addr, 8'h31);
      dw(8'h77, 1'b1, "R8 forwarded write");
      rdp(1'b1, 8'h31 ^ DEV_XOR, 1'b1, "R8 forwarded read");
      rdp(1'b0, 8'h31, 1'b0, "R5 index readback");

      // R9: other device number
      iw(8'h07); dw(8'h04, 1'b0, "R9 select other");
      iw(8'h31);
      rdp(1'b1, 8'hFF, 1'b0, "R9 absent device read");
      dw(8'h42, 1'b0, "R9 absent device write");

      // R11: read and write together on the select register
      iw(8'h07);
      access(1'b1, 1'b1, 8'h06, 1'b1, 8'h04, 1'b0, 1'b0, "R11 select old value");
      rdp(1'b1, 8'h06, 1'b0, "R11 select new value");
      // R11: read and write together on a forwarded register
      iw(8'h40);
      access(1'b1, 1'b1, 8'h99, 1'b1, 8'h40 ^ DEV_XOR, 1'b1, 1'b1, "R11 forwarded both");

      // R3: lock again
      iw(8'hAA);
      rdp(1'b1, 8'hFF, 1'b0, "R3 data read after lock");
      rdp(1'b0, 8'hFF, 1'b0, "R3 index read after lock");
      dw(8'h11, 1'b0, "R4 write after lock");

      // R2: two consecutive keys open again; index kept its pre-lock value
      iw(8'h87);
      iw(8'h87);
      rdp(1'b0, 8'h40, 1'b0, "R2 reopened index");

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R10 scoreboard drained", 8'(exp_q.size()), 8'h00);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule